// File: doc/BRIEF.md
# Reflective Memory Ring Node

This block is one node of a ring of nodes that keep a shared memory in step. A host write port is decoded into two address windows. Both windows map onto one local storage array, and each one is 8 MiB of byte address space. The immediate window starts at address zero. The ordered window starts 16 MiB above it. Every host write that lands in either window leaves the node as a ring packet. The packet holds the node identifier, the word offset, the data and an update-mode bit.

Packets from upstream nodes are written into local storage and passed on downstream unchanged. A packet that carries this node's own identifier has been all the way round the ring, so it is taken off. In the immediate window the local copy is written at the moment the host write is accepted. In the ordered window the local copy is written only when the node's own packet comes back. A host that reads back the new value from the ordered window therefore knows that every other node has already applied it.

Host writes are held in a small queue before transmission. Packets forwarded from the ring get the transmit slot ahead of that queue. Host reads return the contents of local storage with one cycle of latency.

Top module: `rms_node`

## Requirements
- R1: Byte address bits [24:23] select the window: 00 is the immediate window and 10 is the ordered window (base 16 MiB). Bits [22:2] give the word offset. The same offset in either window addresses the same stored word.
- R2: An accepted host write to the immediate window updates local storage on its acceptance edge, so a read issued in the next cycle returns it. It then sends a packet with mode bit 0.
- R3: An accepted host write to the ordered window leaves local storage unchanged and sends a packet with mode bit 1.
- R4: A host packet carries src = node_id_i, off = address bits [22:2] and the written data. Host packets leave in the order the writes were accepted.
- R5: A received packet whose src differs from node_id_i is written to local storage and is sent on unchanged.
- R6: A received packet whose src equals node_id_i is never sent on. It updates storage only when its mode bit is 1.
- R7: When a forwardable received packet and a queued host packet both wait for a free transmit slot, the received packet goes first.
- R8: The host queue holds 4 packets, and hwr_ready_o is low while it is full.
- R9: A write whose address bits [24:23] are 01 or 11 is accepted and dropped: no packet is sent and storage is unchanged. A read of such an address returns zero.
- R10: rd_data_o returns, one cycle after rd_addr_i is presented, the stored word at that offset for either window.
- R11: If a host write to the immediate window and a received write hit the same word in the same cycle, the host data is kept.
- R12: While tx_valid_o is high and tx_ready_i is low, the packet on the transmit port holds steady and rx_ready_o is low.
- R13: Storage holds 256 words, addressed by the low 8 bits of the word offset. Higher offsets wrap onto them, while the packet still carries the full offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | 4 | This node's ring identifier |
| hwr_valid_i | input | 1 | Host write request |
| hwr_ready_o | output | 1 | Host write accepted when high |
| hwr_addr_i | input | 25 | Host write byte address |
| hwr_data_i | input | 32 | Host write data |
| rd_addr_i | input | 25 | Host read byte address |
| rd_data_o | output | 32 | Read data, one cycle after the address |
| rx_valid_i | input | 1 | Packet from upstream valid |
| rx_ready_o | output | 1 | Upstream packet accepted when high |
| rx_src_i | input | 4 | Received packet source node |
| rx_mode_i | input | 1 | Received packet mode (0 immediate, 1 ordered) |
| rx_off_i | input | 21 | Received packet word offset |
| rx_data_i | input | 32 | Received packet data |
| tx_valid_o | output | 1 | Packet to downstream valid |
| tx_ready_i | input | 1 | Downstream accepts packet |
| tx_src_o | output | 4 | Transmitted packet source node |
| tx_mode_o | output | 1 | Transmitted packet mode |
| tx_off_o | output | 21 | Transmitted packet word offset |
| tx_data_o | output | 32 | Transmitted packet data |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a host write to the immediate window and a received packet from another node, aimed at the same word. The bench drives both on one edge. It then reads the word back and expects the host data. It also expects the forwarded packet to leave ahead of the host packet. The second pair is a forwarded packet and a waiting host packet competing for the transmit slot: the bench fills the host queue while downstream is stalled, then releases the stall in the same cycle that a foreign packet arrives, and the scoreboard requires the transmit order first host packet, forwarded packet, remaining host packets.

// File: rtl/rms_pkg.sv
`timescale 1ns/1ps
package rms_pkg;
  typedef enum logic [1:0] {
    WIN_NONE    = 2'd0,
    WIN_PLAIN   = 2'd1,
    WIN_DELAYED = 2'd2
  } win_e;

  localparam logic MODE_IMM = 1'b0;
  localparam logic MODE_DLY = 1'b1;

  // window select codes in the bits above one window
  localparam int SEL_PLAIN   = 0;
  localparam int SEL_DELAYED = 2;
endpackage

// File: rtl/rms_addr_dec.sv
`timescale 1ns/1ps
module rms_addr_dec
  import rms_pkg::*;
#(
  parameter int WIN_LOG2 = 23,
  parameter int ADDR_W   = WIN_LOG2 + 2
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output win_e                win_o,
  output logic [WIN_LOG2-3:0] off_o
);
  localparam int SEL_W = ADDR_W - WIN_LOG2;

  logic [SEL_W-1:0] sel;
  logic             unused_byte_lane;

  assign sel              = addr_i[ADDR_W-1:WIN_LOG2];
  assign off_o            = addr_i[WIN_LOG2-1:2];
  assign unused_byte_lane = ^addr_i[1:0];

  always_comb begin
    if (sel == SEL_W'(SEL_PLAIN))        win_o = WIN_PLAIN;
    else if (sel == SEL_W'(SEL_DELAYED)) win_o = WIN_DELAYED;
    else                                 win_o = WIN_NONE;
  end
endmodule

// File: rtl/rms_wr_fifo.sv
`timescale 1ns/1ps
module rms_wr_fifo #(
  parameter int W     = 58,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign data_o  = store_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) store_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rms_mem.sv
`timescale 1ns/1ps
module rms_mem #(
  parameter int DATA_W = 32,
  parameter int AW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wa_en_i,
  input  logic [AW-1:0]     wa_addr_i,
  input  logic [DATA_W-1:0] wa_data_i,
  input  logic              wb_en_i,
  input  logic [AW-1:0]     wb_addr_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              rd_hit_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // port a (host) overrides port b (ring) on a shared word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wa_en_i && wa_addr_i == AW'(i))      mem_q[i] <= wa_data_i;
        else if (wb_en_i && wb_addr_i == AW'(i)) mem_q[i] <= wb_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_data_o <= '0;
    else if (rd_hit_i) rd_data_o <= mem_q[rd_addr_i];
    else               rd_data_o <= '0;
  end

  assert_host_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa_en_i && wb_en_i && wa_addr_i == wb_addr_i)
      |=> mem_q[$past(wa_addr_i)] == $past(wa_data_i));
endmodule

// File: rtl/rms_tx_arb.sv
`timescale 1ns/1ps
module rms_tx_arb #(
  parameter int PKT_W = 58
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fwd_valid_i,
  input  logic [PKT_W-1:0] fwd_pkt_i,
  input  logic             host_valid_i,
  input  logic [PKT_W-1:0] host_pkt_i,
  input  logic             tx_ready_i,
  output logic             slot_free_o,
  output logic             fwd_take_o,
  output logic             host_pop_o,
  output logic             tx_valid_o,
  output logic [PKT_W-1:0] tx_pkt_o
);
  logic             tx_valid_q;
  logic [PKT_W-1:0] tx_pkt_q;

  assign slot_free_o = !tx_valid_q || tx_ready_i;
  assign fwd_take_o  = slot_free_o && fwd_valid_i;
  assign host_pop_o  = slot_free_o && host_valid_i && !fwd_valid_i;
  assign tx_valid_o  = tx_valid_q;
  assign tx_pkt_o    = tx_pkt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_q <= 1'b0;
      tx_pkt_q   <= '0;
    end else if (slot_free_o) begin
      tx_valid_q <= fwd_valid_i || host_valid_i;
      if (fwd_valid_i)       tx_pkt_q <= fwd_pkt_i;
      else if (host_valid_i) tx_pkt_q <= host_pkt_i;
    end
  end

  assert_tx_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_pkt_o)));
  assert_fwd_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_i && host_valid_i && slot_free_o) |=> (tx_pkt_o == $past(fwd_pkt_i)));
endmodule

// File: rtl/rms_node.sv
`timescale 1ns/1ps
module rms_node
  import rms_pkg::*;
#(
  parameter int NODE_W     = 4,
  parameter int DATA_W     = 32,
  parameter int WIN_LOG2   = 23,
  parameter int MEM_AW     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NODE_W-1:0]     node_id_i,
  input  logic                  hwr_valid_i,
  output logic                  hwr_ready_o,
  input  logic [WIN_LOG2+1:0]   hwr_addr_i,
  input  logic [DATA_W-1:0]     hwr_data_i,
  input  logic [WIN_LOG2+1:0]   rd_addr_i,
  output logic [DATA_W-1:0]     rd_data_o,
  input  logic                  rx_valid_i,
  output logic                  rx_ready_o,
  input  logic [NODE_W-1:0]     rx_src_i,
  input  logic                  rx_mode_i,
  input  logic [WIN_LOG2-3:0]   rx_off_i,
  input  logic [DATA_W-1:0]     rx_data_i,
  output logic                  tx_valid_o,
  input  logic                  tx_ready_i,
  output logic [NODE_W-1:0]     tx_src_o,
  output logic                  tx_mode_o,
  output logic [WIN_LOG2-3:0]   tx_off_o,
  output logic [DATA_W-1:0]     tx_data_o
);
  localparam int ADDR_W = WIN_LOG2 + 2;
  localparam int OFF_W  = WIN_LOG2 - 2;
  localparam int PKT_W  = NODE_W + 1 + OFF_W + DATA_W;

  // host write decode
  win_e             hwr_win;
  logic [OFF_W-1:0] hwr_off;
  logic             hwr_fire, host_we, q_push, q_pop, q_empty, q_full;
  logic [PKT_W-1:0] q_in, q_out;

  rms_addr_dec #(.WIN_LOG2(WIN_LOG2), .ADDR_W(ADDR_W)) u_wr_dec (
    .addr_i(hwr_addr_i), .win_o(hwr_win), .off_o(hwr_off)
  );

  assign hwr_ready_o = !q_full;
  assign hwr_fire    = hwr_valid_i && hwr_ready_o;
  assign host_we     = hwr_fire && (hwr_win == WIN_PLAIN);
  assign q_push      = hwr_fire && (hwr_win != WIN_NONE);
  assign q_in        = {node_id_i, (hwr_win == WIN_DELAYED) ? MODE_DLY : MODE_IMM,
                        hwr_off, hwr_data_i};

  rms_wr_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(q_push), .data_i(q_in), .pop_i(q_pop),
    .data_o(q_out), .empty_o(q_empty), .full_o(q_full)
  );

  // ring receive
  logic             rx_own, rx_fire, ring_we, fwd_take, slot_free;
  logic [PKT_W-1:0] rx_pkt, tx_pkt;

  assign rx_own     = (rx_src_i == node_id_i);
  assign rx_fire    = rx_valid_i && rx_ready_o;
  assign ring_we    = rx_fire && (!rx_own || rx_mode_i == MODE_DLY);
  assign rx_pkt     = {rx_src_i, rx_mode_i, rx_off_i, rx_data_i};
  assign rx_ready_o = slot_free;

  rms_tx_arb #(.PKT_W(PKT_W)) u_arb (
    .clk_i, .rst_ni,
    .fwd_valid_i(rx_valid_i && !rx_own), .fwd_pkt_i(rx_pkt),
    .host_valid_i(!q_empty), .host_pkt_i(q_out),
    .tx_ready_i,
    .slot_free_o(slot_free), .fwd_take_o(fwd_take), .host_pop_o(q_pop),
    .tx_valid_o, .tx_pkt_o(tx_pkt)
  );

  assign {tx_src_o, tx_mode_o, tx_off_o, tx_data_o} = tx_pkt;

  // local storage and host read
  win_e             rd_win;
  logic [OFF_W-1:0] rd_off;
  logic             rd_hit;
  logic             unused_rd_hi;

  rms_addr_dec #(.WIN_LOG2(WIN_LOG2), .ADDR_W(ADDR_W)) u_rd_dec (
    .addr_i(rd_addr_i), .win_o(rd_win), .off_o(rd_off)
  );

  assign rd_hit       = (rd_win != WIN_NONE);
  assign unused_rd_hi = ^rd_off[OFF_W-1:MEM_AW];

  rms_mem #(.DATA_W(DATA_W), .AW(MEM_AW)) u_mem (
    .clk_i, .rst_ni,
    .wa_en_i(host_we), .wa_addr_i(hwr_off[MEM_AW-1:0]), .wa_data_i(hwr_data_i),
    .wb_en_i(ring_we), .wb_addr_i(rx_off_i[MEM_AW-1:0]), .wb_data_i(rx_data_i),
    .rd_hit_i(rd_hit), .rd_addr_i(rd_off[MEM_AW-1:0]), .rd_data_o
  );

  assert_strip_own_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_fire && rx_own) |-> !fwd_take);
  assert_oow_read_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rd_hit) |-> (rd_data_o == '0));
  assert_stall_rx_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |-> !rx_ready_o);
endmodule

// File: tb/rms_node_tb_top.sv
`timescale 1ns/1ps
module rms_node_tb_top;
  localparam logic [3:0] ME    = 4'd3;
  localparam logic [3:0] OTHER = 4'd5;
  localparam logic [24:0] DLY_BASE = 25'h100_0000;

  typedef struct packed {
    logic [3:0]  src;
    logic        mode;
    logic [20:0] off;
    logic [31:0] data;
  } pkt_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hwr_valid = 1'b0, rx_valid = 1'b0, tx_ready = 1'b1, rx_mode = 1'b0;
  logic [24:0] hwr_addr = '0, rd_addr = '0;
  logic [31:0] hwr_data = '0, rx_data = '0;
  logic [3:0]  rx_src = '0;
  logic [20:0] rx_off = '0;
  logic        hwr_ready, rx_ready, tx_valid, tx_mode;
  logic [31:0] rd_data, tx_data;
  logic [3:0]  tx_src;
  logic [20:0] tx_off;

  int   n_tests = 0, n_fail = 0;
  pkt_t exp_q[$];
  bit   done = 1'b0;

  always #4 clk = ~clk;

  rms_node dut_i (
    .clk_i(clk), .rst_ni(rst_n), .node_id_i(ME),
    .hwr_valid_i(hwr_valid), .hwr_ready_o(hwr_ready), .hwr_addr_i(hwr_addr), .hwr_data_i(hwr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_src_i(rx_src), .rx_mode_i(rx_mode),
    .rx_off_i(rx_off), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_src_o(tx_src), .tx_mode_o(tx_mode),
    .tx_off_o(tx_off), .tx_data_o(tx_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic pkt_t host_pkt(input logic [24:0] a, input logic [31:0] d);
    pkt_t p;
    p.src  = ME;
    p.mode = (a[24:23] == 2'b10);
    p.off  = a[22:2];
    p.data = d;
    return p;
  endfunction

  // scoreboard monitor: compares each transmitted packet against the queue
  always begin
    @(negedge clk);
    #2;
    if (rst_n && tx_valid && tx_ready) begin
      pkt_t act;
      act = {tx_src, tx_mode, tx_off, tx_data};
      if (exp_q.size() == 0) chk(1'b0, "R4 R6 unexpected tx", 64'(act), 64'd0);
      else begin
        pkt_t e;
        e = exp_q.pop_front();
        chk(act == e, "R4 R5 R7 tx packet", 64'(act), 64'(e));
      end
    end
  end

  task automatic host_wr(input logic [24:0] a, input logic [31:0] d);
    @(negedge clk);
    hwr_valid = 1'b1; hwr_addr = a; hwr_data = d;
    while (!hwr_ready) @(negedge clk);
    if (a[23] == 1'b0) exp_q.push_back(host_pkt(a, d));
    @(posedge clk);
    #1 hwr_valid = 1'b0;
  endtask

  task automatic rx_send(input logic [3:0] s, input logic m, input logic [20:0] o, input logic [31:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_src = s; rx_mode = m; rx_off = o; rx_data = d;
    while (!rx_ready) @(negedge clk);
    if (s != ME) exp_q.push_back('{s, m, o, d});
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [24:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    chk(rd_data == e, req, 64'(rd_data), 64'(e));
  endtask

  task automatic drain;
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 R5 all expected packets sent", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    #(8 * 20000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_valid == 1'b0 && hwr_ready == 1'b1, "reset tx idle", 64'({tx_valid, hwr_ready}), 64'b01);
    rst_n = 1'b1;
    rd_chk(25'd20, 32'd0, "R10 reset storage zero");

    // R2 R4 immediate window
    host_wr(25'd5 << 2, 32'hA5A5_0005);
    rd_chk(25'd5 << 2, 32'hA5A5_0005, "R2 immediate local update");
    rd_chk(DLY_BASE | (25'd5 << 2), 32'hA5A5_0005, "R1 R10 alias read via ordered window");
    drain();

    // R5 foreign packet
    rx_send(OTHER, 1'b0, 21'd7, 32'hBEEF_0007);
    rd_chk(25'd7 << 2, 32'hBEEF_0007, "R5 foreign write applied");
    drain();

    // R3 R6 ordered window round trip
    host_wr(DLY_BASE | (25'd60 << 2), 32'hD00D_0060);
    drain();
    rd_chk(25'd60 << 2, 32'd0, "R3 ordered write not applied locally");
    rx_send(ME, 1'b1, 21'd60, 32'hD00D_0060);
    rd_chk(25'd60 << 2, 32'hD00D_0060, "R6 own ordered packet applied");
    rx_send(ME, 1'b0, 21'd60, 32'h1111_2222);
    rd_chk(25'd60 << 2, 32'hD00D_0060, "R6 own immediate packet ignored");
    drain();

    // R11 same-cycle host and ring write to one word
    @(negedge clk);
    chk(hwr_ready && rx_ready, "R11 both ports ready", 64'({hwr_ready, rx_ready}), 64'b11);
    hwr_valid = 1'b1; hwr_addr = 25'd40 << 2; hwr_data = 32'hAAAA_0040;
    rx_valid = 1'b1; rx_src = OTHER; rx_mode = 1'b0; rx_off = 21'd40; rx_data = 32'hBBBB_0040;
    exp_q.push_back('{OTHER, 1'b0, 21'd40, 32'hBBBB_0040});
    exp_q.push_back(host_pkt(25'd40 << 2, 32'hAAAA_0040));
    @(posedge clk);
    #1 begin hwr_valid = 1'b0; rx_valid = 1'b0; end
    rd_chk(25'd40 << 2, 32'hAAAA_0040, "R11 host data kept");
    drain();

    // R9 out-of-window
    host_wr(25'h080_0000 | (25'd40 << 2), 32'h9999_9999);
    host_wr(25'h180_0000 | (25'd40 << 2), 32'h8888_8888);
    drain();
    rd_chk(25'd40 << 2, 32'hAAAA_0040, "R9 gap write ignored");
    rd_chk(25'h080_0000 | (25'd40 << 2), 32'd0, "R9 gap read zero");
    rd_chk(25'h180_0000 | (25'd40 << 2), 32'd0, "R9 upper read zero");

    // R13 wrap
    host_wr(25'd256 << 2, 32'hC0DE_0100);
    rd_chk(25'd0, 32'hC0DE_0100, "R13 offset wraps onto word 0");
    drain();

    // R7 R8 R12 stall, full queue, priority
    @(negedge clk);
    tx_ready = 1'b0;
    for (int i = 0; i < 5; i++) host_wr(25'(10 + i) << 2, 32'h5000_0000 + 32'(i));
    @(negedge clk);
    chk(hwr_ready == 1'b0, "R8 ready low when full", 64'(hwr_ready), 64'd0);
    chk(tx_valid && tx_data == 32'h5000_0000, "R12 head held", 64'(tx_data), 64'h5000_0000);
    chk(rx_ready == 1'b0, "R12 rx stalled", 64'(rx_ready), 64'd0);
    repeat (3) @(negedge clk);
    chk(tx_valid && tx_data == 32'h5000_0000 && tx_off == 21'd10, "R12 head stable",
        64'(tx_data), 64'h5000_0000);
    rx_valid = 1'b1; rx_src = OTHER; rx_mode = 1'b0; rx_off = 21'd99; rx_data = 32'hF0F0_0099;
    tx_ready = 1'b1;
    exp_q.insert(1, '{OTHER, 1'b0, 21'd99, 32'hF0F0_0099});
    @(posedge clk);
    #1 rx_valid = 1'b0;
    drain();
    @(negedge clk);
    chk(hwr_ready == 1'b1, "R8 ready back after drain", 64'(hwr_ready), 64'd1);
    rd_chk(25'd99 << 2, 32'hF0F0_0099, "R5 R7 forwarded word stored");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule